// File: doc/BRIEF.md
# Two-Level Graphics Aperture Translator

The block maps bus addresses that land inside a graphics aperture window to physical addresses. Software loads a first-level directory of 64 entries, one register write per entry. Each entry points at a 4 KiB page in system memory that holds 1024 second-level entries of 32 bits. A translation request subtracts the aperture base from the upper address bits to get a directory slot. It checks that slot against the configured aperture size and against the slot's present flag. It then fetches one second-level entry over a memory request/response port. A four-entry translation cache sits in front of the walk, so repeated accesses to a page need no memory read.

Configuration is a write-only port of 8-bit offsets. The registers are: control at 0xB0 (bit 7 enables translation), aperture size at 0xB4, directory load at 0xB8, and sticky error status at 0xBC (write 1 to clear, bits also visible on the `status` port). Clearing control bit 7 empties the cache and stops new requests. Setting it again resumes translation, so the usual flush sequence is 0x2200 followed by 0x2280. Only one request is in flight at a time.

The walker has five states. IDLE waits for an accepted request (IDLE to CHECK). CHECK decides: out of range, cache hit or absent directory slot go to RESP; anything else goes to FETCH. FETCH holds the memory request until it is accepted (FETCH to WAIT). WAIT takes the memory response (WAIT to RESP). RESP presents the result for one cycle and returns to IDLE.

Top module: `gart_xlate`

## Requirements
- R1: After reset, req_ready, rsp_valid and mem_req_valid are low and status is 0. req_ready stays low until a write to offset 0xB0 sets bit 7, and goes high once it is set.
- R2: A write to offset 0xB8 loads directory slot wdata[5:0], with wdata[8] as the present flag and wdata[31:12] as the table page base. A walk reads the second-level entry at {base, bus address bits 21:12, 2'b00}.
- R3: The directory slot is bus address bits 31:22 minus aperture base bits 31:22. A valid entry gives rsp_err=0 and rsp_pa={entry[31:12], bus address[11:0]}.
- R4: The aperture size register at 0xB4 takes the values 0, 32, 48 and 56, which allow 64, 32, 16 and 8 directory slots. Any other value is ignored. A slot at or beyond the allowed count, including an address below the base, gives rsp_err=1, sets status bit 2 and makes no memory request.
- R5: A slot whose present flag is clear, including one written with wdata[8]=0, gives rsp_err=2 and sets status bit 0, with no memory request.
- R6: A second-level entry with bit 0 clear gives rsp_err=3 and sets status bit 1. Every error response carries rsp_pa=0.
- R7: A page translated successfully before is served from the cache. rsp_valid rises at the first clock edge after the edge that accepts the request, and no memory request is made. The cache holds four pages and replaces them in round-robin order, so the fifth new page evicts the oldest one.
- R8: A write to 0xB0 with bit 7 clear drops req_ready and empties the cache. After bit 7 is set again, a previously cached page is fetched from memory once more.
- R9: Writing offset 0xBC clears each status bit written as 1 and leaves the bits written as 0.
- R10: req_ready is low in the cycle after a request is accepted. mem_req_valid stays high with an unchanged mem_req_addr until mem_req_ready is seen.
- R11: Failed translations are not cached: repeating a request whose entry was invalid issues a new memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| status | output | 3 | Sticky flags: bit 0 absent slot, bit 1 invalid entry, bit 2 out of range |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address (0 on error) |
| rsp_err | output | 2 | 0 ok, 1 out of range, 2 absent slot, 3 invalid entry |
| mem_req_valid | output | 1 | Second-level entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Second-level entry word |

## Verification
The bench goes after the slot arithmetic at both ends of the window. It sends an address one slot past the full aperture and one below the base. A design that compares without the base subtraction, or that lets the subtraction wrap, would fetch from memory there instead of reporting out of range. It also shrinks and regrows the aperture and writes an unsupported size code, which catches a decoder that takes stray values or uses the wrong slot counts. For replacement, it fills all four cache slots and then checks which page a fifth one evicts, which exposes eviction that is not round-robin. It checks that the flush sequence forces a new read, that error results never hit in the cache, and that a stalled memory port keeps its request and address steady.

// File: rtl/gart_pkg.sv
package gart_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_W      = 12;
    localparam int PN_W        = ADDR_W - PAGE_W;
    localparam int L2_IDX_W    = 10;
    localparam int DIR_REL_W   = ADDR_W - PAGE_W - L2_IDX_W;
    localparam int DIR_DEPTH   = 64;
    localparam int DIR_AW      = $clog2(DIR_DEPTH);
    localparam int STAT_W      = 3;
    localparam int CFG_AW      = 8;

    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'hB0;
    localparam logic [CFG_AW-1:0] OFS_SIZE = 8'hB4;
    localparam logic [CFG_AW-1:0] OFS_DIR  = 8'hB8;
    localparam logic [CFG_AW-1:0] OFS_STAT = 8'hBC;

    localparam int CTRL_EN_BIT  = 7;
    localparam int DIR_PRES_BIT = 8;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_RANGE = 2'd1,
        RSP_DIR   = 2'd2,
        RSP_L2    = 2'd3
    } rsp_code_e;
endpackage

// File: rtl/gart_regs.sv
module gart_regs
    import gart_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic [STAT_W-1:0]   set_flags,
    output logic                en,
    output logic                flush,
    output logic [DIR_AW:0]     limit,
    output logic [STAT_W-1:0]   status,
    output logic                dir_we,
    output logic [DIR_AW-1:0]   dir_widx,
    output logic                dir_wpresent,
    output logic [PN_W-1:0]     dir_wbase
);
    localparam logic [DIR_AW:0] FULL_SLOTS = (DIR_AW+1)'(DIR_DEPTH);

    logic [1:0]        size_sel_q;
    logic [STAT_W-1:0] clr;
    logic              wr_ctrl, wr_size, wr_stat;

    assign wr_ctrl = cfg_we && (cfg_addr == OFS_CTRL);
    assign wr_size = cfg_we && (cfg_addr == OFS_SIZE);
    assign wr_stat = cfg_we && (cfg_addr == OFS_STAT);
    assign clr     = wr_stat ? cfg_wdata[STAT_W-1:0] : '0;

    assign flush        = wr_ctrl && !cfg_wdata[CTRL_EN_BIT];
    assign limit        = FULL_SLOTS >> size_sel_q;
    assign dir_we       = cfg_we && (cfg_addr == OFS_DIR);
    assign dir_widx     = cfg_wdata[DIR_AW-1:0];
    assign dir_wpresent = cfg_wdata[DIR_PRES_BIT];
    assign dir_wbase    = cfg_wdata[ADDR_W-1:PAGE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            size_sel_q <= 2'd0;
            status     <= '0;
        end else begin
            if (wr_ctrl) en <= cfg_wdata[CTRL_EN_BIT];
            if (wr_size) begin
                unique case (cfg_wdata)
                    32'd0:   size_sel_q <= 2'd0;
                    32'd32:  size_sel_q <= 2'd1;
                    32'd48:  size_sel_q <= 2'd2;
                    32'd56:  size_sel_q <= 2'd3;
                    default: size_sel_q <= size_sel_q;
                endcase
            end
            status <= (status & ~clr) | set_flags;
        end
    end

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && set_flags == '0) |=> ((status & $past(cfg_wdata[STAT_W-1:0])) == '0));
endmodule

// File: rtl/gart_dir.sv
module gart_dir
    import gart_pkg::*;
#(
    parameter int DEPTH = DIR_DEPTH,
    parameter int AW    = DIR_AW,
    parameter int BW    = PN_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic          wpresent,
    input  logic [BW-1:0] wbase,
    input  logic [AW-1:0] ridx,
    output logic          rpresent,
    output logic [BW-1:0] rbase
);
    logic [DEPTH-1:0] pres_q;
    logic [BW-1:0]    base_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n)  pres_q       <= '0;
        else if (we) pres_q[widx] <= wpresent;
    end

    always_ff @(posedge clk) begin
        if (we) base_q[widx] <= wbase;
    end

    assign rpresent = pres_q[ridx];
    assign rbase    = base_q[ridx];

    // R5
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ridx == widx) |=> (rpresent == $past(wpresent)) || $changed(ridx));
endmodule

// File: rtl/gart_tlb.sv
module gart_tlb #(
    parameter int DEPTH = 4,
    parameter int TW    = 20,
    parameter int DW    = 20
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [TW-1:0] ltag,
    output logic          hit,
    output logic [DW-1:0] hdata,
    input  logic          fill,
    input  logic [TW-1:0] ftag,
    input  logic [DW-1:0] fdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] match;
    logic [TW-1:0]    tag_q  [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = valid_q[i] && (tag_q[i] == ltag);
    end

    assign hit = |match;

    always_comb begin
        hdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (match[i]) hdata = hdata | data_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill && !flush) begin
            tag_q[ptr_q]  <= ftag;
            data_q[ptr_q] <= fdata;
        end
    end

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/gart_walk.sv
module gart_walk
    import gart_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APER_BASE = 32'hE000_0000
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                flush,
    input  logic [DIR_AW:0]     limit,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_pa,
    output logic [1:0]          rsp_err,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ADDR_W-1:0]   mem_rsp_data,
    output logic [DIR_AW-1:0]   dir_ridx,
    input  logic                dir_present,
    input  logic [PN_W-1:0]     dir_base,
    output logic [PN_W-1:0]     tlb_tag,
    input  logic                tlb_hit,
    input  logic [PN_W-1:0]     tlb_ppn,
    output logic                tlb_fill,
    output logic [PN_W-1:0]     fill_ppn,
    output logic [STAT_W-1:0]   set_flags
);
    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_FETCH, S_WAIT, S_RESP
    } walk_state_e;

    walk_state_e          state_q, state_d;
    logic [ADDR_W-1:0]    addr_q, pa_q, maddr_q;
    rsp_code_e            err_q;
    logic                 stale_q;
    logic [DIR_REL_W-1:0] dir_rel;
    logic                 oor, accept, l2_ok, l2_rsvd_unused;

    assign accept         = (state_q == S_IDLE) && en && req_valid;
    assign dir_rel        = addr_q[ADDR_W-1:ADDR_W-DIR_REL_W] - APER_BASE[ADDR_W-1:ADDR_W-DIR_REL_W];
    assign oor            = dir_rel >= DIR_REL_W'(limit);
    assign dir_ridx       = dir_rel[DIR_AW-1:0];
    assign tlb_tag        = addr_q[ADDR_W-1:PAGE_W];
    assign l2_ok          = mem_rsp_data[0];
    assign l2_rsvd_unused = ^mem_rsp_data[PAGE_W-1:1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_CHECK;
            S_CHECK: state_d = (oor || tlb_hit || !dir_present) ? S_RESP : S_FETCH;
            S_FETCH: if (mem_req_ready) state_d = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            pa_q    <= '0;
            maddr_q <= '0;
            err_q   <= RSP_OK;
            stale_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                stale_q <= 1'b0;
            end else if (flush) begin
                stale_q <= 1'b1;
            end
            if (state_q == S_CHECK) begin
                maddr_q <= {dir_base, addr_q[PAGE_W+L2_IDX_W-1:PAGE_W], 2'b00};
                if (oor) begin
                    err_q <= RSP_RANGE;
                    pa_q  <= '0;
                end else if (tlb_hit) begin
                    err_q <= RSP_OK;
                    pa_q  <= {tlb_ppn, addr_q[PAGE_W-1:0]};
                end else if (!dir_present) begin
                    err_q <= RSP_DIR;
                    pa_q  <= '0;
                end
            end
            if (state_q == S_WAIT && mem_rsp_valid) begin
                err_q <= l2_ok ? RSP_OK : RSP_L2;
                pa_q  <= l2_ok ? {mem_rsp_data[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0]} : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE) && en;
        rsp_valid     = (state_q == S_RESP);
        rsp_pa        = pa_q;
        rsp_err       = err_q;
        mem_req_valid = (state_q == S_FETCH);
        mem_req_addr  = maddr_q;
        tlb_fill      = (state_q == S_WAIT) && mem_rsp_valid && l2_ok && !stale_q && !flush;
        fill_ppn      = mem_rsp_data[ADDR_W-1:PAGE_W];
        set_flags     = '0;
        set_flags[0]  = (state_q == S_CHECK) && !oor && !tlb_hit && !dir_present;
        set_flags[1]  = (state_q == S_WAIT) && mem_rsp_valid && !l2_ok;
        set_flags[2]  = (state_q == S_CHECK) && oor;
    end

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R4
    range_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == RSP_RANGE) |-> !$past(mem_req_valid));
    // R6
    err_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != RSP_OK) |-> (rsp_pa == '0));
    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req_ready);
endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
    import gart_pkg::*;
#(
    parameter logic [ADDR_W-1:0] APER_BASE = 32'hE000_0000,
    parameter int                TLB_DEPTH = 4
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [STAT_W-1:0]   status,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_pa,
    output logic [1:0]          rsp_err,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ADDR_W-1:0]   mem_rsp_data
);
    logic                en, flush, dir_we, dir_wpresent, dir_present;
    logic                tlb_hit, tlb_fill;
    logic [DIR_AW:0]     limit;
    logic [DIR_AW-1:0]   dir_widx, dir_ridx;
    logic [PN_W-1:0]     dir_wbase, dir_base, tlb_tag, tlb_ppn, fill_ppn;
    logic [STAT_W-1:0]   set_flags;

    gart_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .set_flags(set_flags), .en(en), .flush(flush),
        .limit(limit), .status(status), .dir_we(dir_we), .dir_widx(dir_widx),
        .dir_wpresent(dir_wpresent), .dir_wbase(dir_wbase)
    );

    gart_dir u_dir (
        .clk(clk), .rst_n(rst_n), .we(dir_we), .widx(dir_widx),
        .wpresent(dir_wpresent), .wbase(dir_wbase), .ridx(dir_ridx),
        .rpresent(dir_present), .rbase(dir_base)
    );

    gart_tlb #(.DEPTH(TLB_DEPTH), .TW(PN_W), .DW(PN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ltag(tlb_tag),
        .hit(tlb_hit), .hdata(tlb_ppn), .fill(tlb_fill),
        .ftag(tlb_tag), .fdata(fill_ppn)
    );

    gart_walk #(.APER_BASE(APER_BASE)) u_walk (
        .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .limit(limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_err(rsp_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .dir_ridx(dir_ridx),
        .dir_present(dir_present), .dir_base(dir_base), .tlb_tag(tlb_tag),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_fill(tlb_fill),
        .fill_ppn(fill_ppn), .set_flags(set_flags)
    );
endmodule

// File: tb/sim_gart_xlate.sv
module sim_gart_xlate;
    localparam logic [31:0] AB = 32'hE000_0000;
    localparam logic [31:0] TB3 = 32'h0123_4000;
    localparam logic [31:0] TB10 = 32'h0456_7000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  status;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_err;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int mem_cnt = 0;
    int vcyc = 0;
    int stall_cfg = 0;
    int scnt = 0;
    logic in_req = 1'b0;
    logic moved = 1'b0;
    logic [31:0] last_addr = '0;

    logic [1:0]  r_err;
    logic [31:0] r_pa;
    int          r_lat, r_md;
    logic        r_rdy;

    gart_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .status(status), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_err(rsp_err), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] l2_word(input logic [31:0] a);
        return {a[21:2] ^ 20'hC3A51, 11'd0, ~a[11]};
    endfunction

    function automatic logic [31:0] va(input int idx, input int pg, input int off);
        return AB + (32'(idx) << 22) + (32'(pg) << 12) + 32'(off);
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] base, input int pg, input int off);
        logic [31:0] w;
        w = l2_word(base + 32'(pg) * 4);
        return {w[31:12], 12'(off)};
    endfunction

    // memory model for second-level entries
    always @(negedge clk) begin
        if (mem_req_ready) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = l2_word(last_addr);
            mem_cnt++;
            in_req = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            if (mem_req_valid) begin
                vcyc++;
                if (!in_req) scnt = stall_cfg;
                else if (mem_req_addr != last_addr) moved = 1'b1;
                last_addr = mem_req_addr;
                if (scnt > 0) begin
                    scnt--;
                    in_req = 1'b1;
                end else begin
                    mem_req_ready = 1'b1;
                end
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] a);
        int m0;
        m0 = mem_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_rdy = req_ready;
        r_lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            r_lat++;
        end
        r_err = rsp_err;
        r_pa  = rsp_pa;
        r_md  = mem_cnt - m0;
    endtask

    task automatic t_reset();
        chk("R1 req_ready after reset", 32'(req_ready), 0);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1 mem_req_valid after reset", 32'(mem_req_valid), 0);
        chk("R1 status after reset", 32'(status), 0);
        cfg_wr(8'hB0, 32'h2280);
        chk("R1 req_ready after enable", 32'(req_ready), 1);
    endtask

    task automatic t_range();
        do_req(AB + (32'd64 << 22));
        chk("R4 one slot past window err", 32'(r_err), 1);
        chk("R4 past window no fetch", 32'(r_md), 0);
        chk("R4 status bit2", 32'(status), 32'h4);
        do_req(32'hD000_0000);
        chk("R4 below base err", 32'(r_err), 1);
        chk("R6 error pa zero", r_pa, 0);
    endtask

    task automatic t_absent();
        do_req(va(3, 5, 0));
        chk("R5 absent slot err", 32'(r_err), 2);
        chk("R5 absent no fetch", 32'(r_md), 0);
        chk("R5 status bit0", 32'(status), 32'h5);
    endtask

    task automatic t_w1c();
        cfg_wr(8'hBC, 32'h0);
        chk("R9 zero write keeps", 32'(status), 32'h5);
        cfg_wr(8'hBC, 32'h4);
        chk("R9 clear bit2 only", 32'(status), 32'h1);
        cfg_wr(8'hBC, 32'h1);
        chk("R9 clear bit0", 32'(status), 32'h0);
    endtask

    task automatic t_walk();
        cfg_wr(8'hB8, TB3 | 32'h100 | 32'd3);
        do_req(va(3, 5, 12'hABC));
        chk("R3 walk err", 32'(r_err), 0);
        chk("R3 walk pa", r_pa, exp_pa(TB3, 5, 12'hABC));
        chk("R2 entry address", last_addr, 32'h0123_4014);
        chk("R2 one fetch", 32'(r_md), 1);
        chk("R10 ready low after accept", 32'(r_rdy), 0);
        do_req(va(3, 5, 12'h123));
        chk("R7 hit pa", r_pa, exp_pa(TB3, 5, 12'h123));
        chk("R7 hit latency", 32'(r_lat), 2);
        chk("R7 hit no fetch", 32'(r_md), 0);
    endtask

    task automatic t_invalid();
        do_req(va(3, 12'h205, 0));
        chk("R6 invalid entry err", 32'(r_err), 3);
        chk("R6 invalid pa zero", r_pa, 0);
        chk("R6 status bit1", 32'(status), 32'h2);
        do_req(va(3, 12'h205, 4));
        chk("R11 invalid refetched", 32'(r_md), 1);
        cfg_wr(8'hBC, 32'h2);
    endtask

    task automatic t_round_robin();
        for (int p = 6; p <= 8; p++) begin
            do_req(va(3, p, 0));
            chk("R7 fill pa", r_pa, exp_pa(TB3, p, 0));
        end
        do_req(va(3, 5, 8));
        chk("R7 four pages resident", 32'(r_md), 0);
        do_req(va(3, 9, 0));
        chk("R7 fifth page fetched", 32'(r_md), 1);
        do_req(va(3, 6, 0));
        chk("R7 second-oldest kept", 32'(r_md), 0);
        do_req(va(3, 5, 0));
        chk("R7 oldest evicted", 32'(r_md), 1);
        chk("R7 refetched pa", r_pa, exp_pa(TB3, 5, 0));
    endtask

    task automatic t_size();
        cfg_wr(8'hB8, TB10 | 32'h100 | 32'd10);
        cfg_wr(8'hB4, 32'd56);
        do_req(va(10, 1, 0));
        chk("R4 eight-slot window", 32'(r_err), 1);
        cfg_wr(8'hB4, 32'd5);
        do_req(va(10, 1, 0));
        chk("R4 bad size code ignored", 32'(r_err), 1);
        cfg_wr(8'hB4, 32'd32);
        do_req(va(10, 1, 0));
        chk("R4 32-slot in range", 32'(r_err), 0);
        chk("R3 second table pa", r_pa, exp_pa(TB10, 1, 0));
        do_req(va(40, 0, 0));
        chk("R4 32-slot out of range", 32'(r_err), 1);
        cfg_wr(8'hB4, 32'd48);
        do_req(va(15, 0, 0));
        chk("R4 16-slot last slot", 32'(r_err), 2);
        do_req(va(16, 0, 0));
        chk("R4 16-slot first outside", 32'(r_err), 1);
        cfg_wr(8'hB4, 32'd0);
        cfg_wr(8'hBC, 32'h7);
    endtask

    task automatic t_unload();
        cfg_wr(8'hB8, 32'd10);
        do_req(va(10, 2, 0));
        chk("R5 index-only write clears slot", 32'(r_err), 2);
        cfg_wr(8'hBC, 32'h7);
    endtask

    task automatic t_flush();
        cfg_wr(8'hB0, 32'h2200);
        chk("R8 ready low while disabled", 32'(req_ready), 0);
        cfg_wr(8'hB0, 32'h2280);
        chk("R8 ready back", 32'(req_ready), 1);
        do_req(va(3, 5, 0));
        chk("R8 cached page refetched", 32'(r_md), 1);
        chk("R8 refetch pa", r_pa, exp_pa(TB3, 5, 0));
    endtask

    task automatic t_stall();
        int v0;
        v0 = vcyc;
        stall_cfg = 3;
        do_req(va(3, 12'h030, 0));
        stall_cfg = 0;
        chk("R10 request held over stall", 32'(vcyc - v0), 4);
        chk("R10 address steady", 32'(moved), 0);
        chk("R10 stalled latency", 32'(r_lat), 7);
        chk("R10 stalled pa", r_pa, exp_pa(TB3, 12'h030, 0));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_range();
        t_absent();
        t_w1c();
        t_walk();
        t_invalid();
        t_round_robin();
        t_size();
        t_unload();
        t_flush();
        t_stall();
        repeat (3) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end
endmodule